// File: doc/BRIEF.md
# Half-Duplex Serial Character Transceiver

This block moves 8-bit characters over a single-wire style serial link. One bit engine either sends or receives, never both at once, which suits smart-card links where the card and the reader share one data line. The bit period is set in system clocks through `bit_clocks`. Its 13-bit range reaches the 372-clock default of such links. Three run-time inputs select the stop-bit count, the parity sense and the data bit order. A separate divider produces the clock that is handed to the card.

A frame consists of a low start bit, eight data bits, a parity bit and one or two high stop bits. To send, the user presents `tx_byte` and pulses `tx_start` while the engine is idle. To receive, the user waits for `rx_ready`, reads `rx_byte`, and pulses `flag_ack` to clear the sticky receive flags. The serial input passes through a two-stage synchronizer before the engine sees it. A falling edge is accepted as a start bit only if the line is still low half a bit period later. After that, each later bit is sampled one full period apart, which places every sample at the middle of its bit.

Top module: `hdx_serial_xcvr`

## Requirements
- R1: Out of reset `ser_out` is 1 and `tx_full`, `rx_active`, `rx_start_seen`, `rx_ready`, `rx_overrun`, `rx_frame_err` are 0. `ser_out` stays 1 whenever `tx_full` is 0, and that includes the whole of a reception.
- R2: A `tx_start` seen at an idle clock edge with the synchronized line high commits `tx_byte`. From the next cycle `tx_full` is 1 and `ser_out` carries the start bit (0). Every frame bit lasts exactly `bit_clocks` cycles.
- R3: With `msb_first`=1 the data bits go out b7 first and end with b0. With `msb_first`=0 they go out b0 first. Reception reassembles the byte in the same order.
- R4: The parity bit follows the data. With `parity_odd`=1 the eight data bits plus parity hold an odd number of ones. With `parity_odd`=0 they hold an even number.
- R5: `two_stop`=0 sends one high stop bit and `two_stop`=1 sends two. `tx_full` stays 1 for exactly 11 or 12 bit periods and then returns to 0 while `ser_out` returns high.
- R6: A low level on the synchronized line at an idle edge raises `rx_start_seen` and `rx_active`. If the line is high again half a period (`bit_clocks`/2 cycles) later, the engine returns to idle and no character or flag results.
- R7: Each data bit is sampled `bit_clocks` cycles after the previous sample, that is mid-bit. After the first stop-bit sample, `rx_byte` holds the character and `rx_ready` is 1.
- R8: `rx_frame_err` is set when the first stop bit is sampled low.
- R9: A character that completes while `rx_ready` is already 1 sets `rx_overrun`, and its byte replaces the held one.
- R10: `rx_ready`, `rx_overrun` and `rx_frame_err` stay set until a cycle with `flag_ack`=1 clears them. A completion in the same cycle as `flag_ack` wins, so the flags show that character for at least one cycle.
- R11: `tx_start` is ignored while a reception is under way. When a start bit is detected in the same cycle as a request, reception wins and `tx_full` stays 0.
- R12: `com_clk` has a period of D system clocks and is high for floor(D/2) of them, where D = `clk_div_cfg`. Values below 2 count as 2.
- R13: A bit period of 372 clocks transmits and receives correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_clocks | input | CPB_W (13) | System clocks per serial bit, at least 8 |
| clk_div_cfg | input | DIV_W (8) | System clocks per `com_clk` period |
| two_stop | input | 1 | 1: two stop bits, 0: one |
| parity_odd | input | 1 | 1: odd parity, 0: even |
| msb_first | input | 1 | 1: b7 first, 0: b0 first |
| tx_byte | input | 8 | Character to send |
| tx_start | input | 1 | Transmit request |
| tx_full | output | 1 | Character committed and being sent |
| ser_in | input | 1 | Serial receive line |
| ser_out | output | 1 | Serial transmit line, idles high |
| com_clk | output | 1 | Divided clock for the remote device |
| rx_byte | output | 8 | Last received character |
| rx_ready | output | 1 | Sticky: character available |
| rx_overrun | output | 1 | Sticky: character completed over an unread one |
| rx_frame_err | output | 1 | Sticky: stop bit sampled low |
| flag_ack | input | 1 | Clears the three receive flags |
| rx_active | output | 1 | Engine is receiving |
| rx_start_seen | output | 1 | Engine is qualifying a start bit |

## Verification
Two pairs of events can fall in one cycle. The first is a character completing in the same cycle as `flag_ack`. The bench holds `flag_ack` high through a whole reception, and the completion must still leave `rx_ready` up for exactly one cycle. The second is a start bit being recognized in the same cycle as a transmit request. The bench raises `tx_start` precisely two cycles after dropping `ser_in`, which is the synchronizer delay. The check is that reception takes the engine and `tx_full` stays low until the character ends. A behavioural per-cycle model in the bench judges both cases alongside every other output.

// File: rtl/hdx_pkg.sv
package hdx_pkg;

    localparam int DATA_W = 8;
    localparam int IDX_W  = 4;

    // Frame bit index: 0 start, 1..8 data slots, 9 parity, 10/11 stop.
    localparam logic [IDX_W-1:0] IDX_START    = IDX_W'(0);
    localparam logic [IDX_W-1:0] IDX_FIRSTDAT = IDX_W'(1);
    localparam logic [IDX_W-1:0] IDX_LASTDAT  = IDX_W'(DATA_W);
    localparam logic [IDX_W-1:0] IDX_PARITY   = IDX_W'(DATA_W + 1);
    localparam logic [IDX_W-1:0] IDX_STOP1    = IDX_W'(DATA_W + 2);
    localparam logic [IDX_W-1:0] IDX_STOP2    = IDX_W'(DATA_W + 3);

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_TX,
        ENG_RX_HUNT,
        ENG_RX_BITS
    } eng_state_e;

    typedef struct packed {
        logic two_stop;
        logic parity_odd;
        logic msb_first;
    } frame_cfg_t;

    typedef struct packed {
        logic ready;
        logic overrun;
        logic frame_err;
    } rx_flags_t;

    // Data slot (1..8) to byte bit position.
    function automatic logic [2:0] data_pos(input logic [IDX_W-1:0] idx,
                                            input logic msb);
        logic [IDX_W-1:0] t;
        t = msb ? (IDX_LASTDAT - idx) : (idx - IDX_FIRSTDAT);
        return t[2:0];
    endfunction

    function automatic logic parity_of(input logic [DATA_W-1:0] d,
                                       input logic odd);
        return (^d) ^ odd;
    endfunction

    function automatic logic tx_bit(input logic [DATA_W-1:0] d,
                                    input logic [IDX_W-1:0] idx,
                                    input frame_cfg_t cfg);
        logic b;
        if (idx == IDX_START)
            b = 1'b0;
        else if (idx <= IDX_LASTDAT)
            b = d[data_pos(idx, cfg.msb_first)];
        else if (idx == IDX_PARITY)
            b = parity_of(d, cfg.parity_odd);
        else
            b = 1'b1;
        return b;
    endfunction

    function automatic logic [IDX_W-1:0] last_tx_idx(input frame_cfg_t cfg);
        return cfg.two_stop ? IDX_STOP2 : IDX_STOP1;
    endfunction

endpackage

// File: rtl/hdx_sync2.sv
module hdx_sync2 #(
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic s1_q, s2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= RESET_VAL;
            s2_q <= RESET_VAL;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/hdx_comclk_div.sv
module hdx_comclk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_cfg,
    output logic             com_clk
);
    localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

    logic [DIV_W-1:0] period, half, cnt_q, cnt_nxt;
    logic             com_q;

    always_comb begin
        period  = (div_cfg < MIN_DIV) ? MIN_DIV : div_cfg;
        half    = period >> 1;
        cnt_nxt = (cnt_q >= period - 1'b1) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            com_q <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt;
            com_q <= (cnt_nxt < half);
        end
    end

    assign com_clk = com_q;
endmodule

// File: rtl/hdx_bit_engine.sv
module hdx_bit_engine
    import hdx_pkg::*;
#(
    parameter int CPB_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CPB_W-1:0]  bit_clocks,
    input  frame_cfg_t        cfg,
    input  logic              line,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              tx_start,
    output logic              ser_out,
    output logic              tx_busy,
    output logic              rx_busy,
    output logic              rx_hunt,
    output logic              rx_done,
    output logic              rx_stop,
    output logic [DATA_W-1:0] rx_word
);
    eng_state_e        state_q;
    logic [CPB_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] tx_data_q;
    logic [DATA_W-1:0] rx_sh_q;
    logic              ser_q;
    logic              bit_end, half_end;

    assign bit_end  = (cnt_q == bit_clocks - 1'b1);
    assign half_end = (cnt_q == (bit_clocks >> 1) - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ENG_IDLE;
            cnt_q     <= '0;
            idx_q     <= '0;
            tx_data_q <= '0;
            rx_sh_q   <= '0;
            ser_q     <= 1'b1;
        end else begin
            unique case (state_q)
                ENG_IDLE: begin
                    cnt_q <= '0;
                    idx_q <= IDX_START;
                    if (!line) begin
                        state_q <= ENG_RX_HUNT;
                    end else if (tx_start) begin
                        state_q   <= ENG_TX;
                        tx_data_q <= tx_byte;
                        ser_q     <= 1'b0;
                    end
                end
                ENG_TX: begin
                    if (bit_end) begin
                        cnt_q <= '0;
                        if (idx_q == last_tx_idx(cfg)) begin
                            state_q <= ENG_IDLE;
                            ser_q   <= 1'b1;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                            ser_q <= tx_bit(tx_data_q, idx_q + 1'b1, cfg);
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ENG_RX_HUNT: begin
                    if (half_end) begin
                        cnt_q <= '0;
                        if (!line) begin
                            state_q <= ENG_RX_BITS;
                            idx_q   <= IDX_FIRSTDAT;
                        end else begin
                            state_q <= ENG_IDLE;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ENG_RX_BITS: begin
                    if (bit_end) begin
                        cnt_q <= '0;
                        if (idx_q <= IDX_LASTDAT)
                            rx_sh_q[data_pos(idx_q, cfg.msb_first)] <= line;
                        if (idx_q == IDX_STOP1)
                            state_q <= ENG_IDLE;
                        else
                            idx_q <= idx_q + 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end

    assign ser_out = ser_q;
    assign tx_busy = (state_q == ENG_TX);
    assign rx_hunt = (state_q == ENG_RX_HUNT);
    assign rx_busy = (state_q == ENG_RX_HUNT) || (state_q == ENG_RX_BITS);
    assign rx_done = (state_q == ENG_RX_BITS) && bit_end && (idx_q == IDX_STOP1);
    assign rx_stop = line;
    assign rx_word = rx_sh_q;
endmodule

// File: rtl/hdx_rx_flags.sv
module hdx_rx_flags
    import hdx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  logic              stop_bit,
    input  logic [DATA_W-1:0] word,
    input  logic              ack,
    output rx_flags_t         flags,
    output logic [DATA_W-1:0] byte_out
);
    rx_flags_t         flags_q;
    logic [DATA_W-1:0] byte_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            byte_q  <= '0;
        end else if (done) begin
            byte_q            <= word;
            flags_q.ready     <= 1'b1;
            flags_q.overrun   <= flags_q.overrun | flags_q.ready;
            flags_q.frame_err <= flags_q.frame_err | ~stop_bit;
        end else if (ack) begin
            flags_q <= '0;
        end
    end

    assign flags    = flags_q;
    assign byte_out = byte_q;
endmodule

// File: rtl/hdx_serial_xcvr.sv
module hdx_serial_xcvr
    import hdx_pkg::*;
#(
    parameter int CPB_W = 13,
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CPB_W-1:0]  bit_clocks,
    input  logic [DIV_W-1:0]  clk_div_cfg,
    input  logic              two_stop,
    input  logic              parity_odd,
    input  logic              msb_first,
    input  logic [7:0]        tx_byte,
    input  logic              tx_start,
    output logic              tx_full,
    input  logic              ser_in,
    output logic              ser_out,
    output logic              com_clk,
    output logic [7:0]        rx_byte,
    output logic              rx_ready,
    output logic              rx_overrun,
    output logic              rx_frame_err,
    input  logic              flag_ack,
    output logic              rx_active,
    output logic              rx_start_seen
);
    frame_cfg_t        cfg;
    rx_flags_t         flags;
    logic              line;
    logic              done, stop_bit;
    logic [DATA_W-1:0] word;

    assign cfg = '{two_stop: two_stop, parity_odd: parity_odd, msb_first: msb_first};

    hdx_sync2 #(.RESET_VAL(1'b1)) u_sync (
        .clk(clk), .rst(rst), .d(ser_in), .q(line)
    );

    hdx_comclk_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst(rst), .div_cfg(clk_div_cfg), .com_clk(com_clk)
    );

    hdx_bit_engine #(.CPB_W(CPB_W)) u_eng (
        .clk(clk), .rst(rst), .bit_clocks(bit_clocks), .cfg(cfg),
        .line(line), .tx_byte(tx_byte), .tx_start(tx_start),
        .ser_out(ser_out), .tx_busy(tx_full), .rx_busy(rx_active),
        .rx_hunt(rx_start_seen), .rx_done(done), .rx_stop(stop_bit),
        .rx_word(word)
    );

    hdx_rx_flags u_flags (
        .clk(clk), .rst(rst), .done(done), .stop_bit(stop_bit),
        .word(word), .ack(flag_ack), .flags(flags), .byte_out(rx_byte)
    );

    assign rx_ready     = flags.ready;
    assign rx_overrun   = flags.overrun;
    assign rx_frame_err = flags.frame_err;
endmodule

// File: rtl/hdx_serial_xcvr_chk.sv
module hdx_serial_xcvr_chk (
    input logic clk,
    input logic rst,
    input logic ser_out,
    input logic tx_full,
    input logic tx_start,
    input logic rx_active,
    input logic rx_start_seen,
    input logic rx_ready,
    input logic rx_overrun,
    input logic rx_frame_err,
    input logic flag_ack
);
    assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
        !tx_full |-> ser_out);

    assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_full) |-> !ser_out);

    assert_hunt_in_rx_R6: assert property (@(posedge clk) disable iff (rst)
        rx_start_seen |-> rx_active);

    assert_ferr_with_char_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_frame_err) |-> (rx_ready && $past(rx_active)));

    assert_ovr_needs_ready_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_overrun) |-> $past(rx_ready));

    assert_ready_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (rx_ready && !flag_ack) |=> rx_ready);

    assert_ferr_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (rx_frame_err && !flag_ack) |=> rx_frame_err);

    assert_ack_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (flag_ack && !rx_active) |=> (!rx_ready && !rx_overrun && !rx_frame_err));

    assert_req_ignored_rx_R11: assert property (@(posedge clk) disable iff (rst)
        (rx_active && tx_start) |=> !tx_full);

    assert_one_direction_R11: assert property (@(posedge clk) disable iff (rst)
        !(tx_full && rx_active));
endmodule

bind hdx_serial_xcvr hdx_serial_xcvr_chk u_chk (
    .clk(clk), .rst(rst), .ser_out(ser_out), .tx_full(tx_full),
    .tx_start(tx_start), .rx_active(rx_active), .rx_start_seen(rx_start_seen),
    .rx_ready(rx_ready), .rx_overrun(rx_overrun), .rx_frame_err(rx_frame_err),
    .flag_ack(flag_ack)
);

// File: tb/hdx_serial_xcvr_bench.sv
module hdx_serial_xcvr_bench;
    localparam int CPB_W = 13;
    localparam int DIV_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [CPB_W-1:0] bit_clocks = 13'd16;
    logic [DIV_W-1:0] clk_div_cfg = 8'd4;
    logic two_stop = 1'b0, parity_odd = 1'b0, msb_first = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic tx_start = 1'b0, flag_ack = 1'b0, ser_in = 1'b1;
    logic tx_full, ser_out, com_clk, rx_ready, rx_overrun, rx_frame_err;
    logic rx_active, rx_start_seen;
    logic [7:0] rx_byte;

    hdx_serial_xcvr #(.CPB_W(CPB_W), .DIV_W(DIV_W)) u_hdx_serial_xcvr (
        .clk(clk), .rst(rst), .bit_clocks(bit_clocks), .clk_div_cfg(clk_div_cfg),
        .two_stop(two_stop), .parity_odd(parity_odd), .msb_first(msb_first),
        .tx_byte(tx_byte), .tx_start(tx_start), .tx_full(tx_full),
        .ser_in(ser_in), .ser_out(ser_out), .com_clk(com_clk),
        .rx_byte(rx_byte), .rx_ready(rx_ready), .rx_overrun(rx_overrun),
        .rx_frame_err(rx_frame_err), .flag_ack(flag_ack),
        .rx_active(rx_active), .rx_start_seen(rx_start_seen)
    );

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    function automatic bit fbit(input logic [7:0] d, input int k,
                                input bit msb, input bit odd);
        if (k == 0) return 1'b0;
        if (k <= 8) return msb ? d[8-k] : d[k-1];
        if (k == 9) return (^d) ^ odd;
        return 1'b1;
    endfunction

    // ---------------- behavioural reference model ----------------
    bit       m_s1 = 1'b1, m_s2 = 1'b1;
    bit       mq[$];
    bit       e_out = 1'b1, e_full = 1'b0;
    int       r_mode = 0, r_wait = 0, r_idx = 0;
    bit [7:0] r_sh = 8'h00, e_byte = 8'h00;
    bit       e_rdy = 1'b0, e_ovr = 1'b0, e_fe = 1'b0;

    always @(posedge clk) begin
        bit line, done, stop_v, tx_was;
        int p, h, nbits;
        cycles++;
        if (rst) begin
            m_s1 = 1'b1; m_s2 = 1'b1; mq.delete();
            e_out = 1'b1; e_full = 1'b0; r_mode = 0; r_wait = 0; r_idx = 0;
            r_sh = 8'h00; e_byte = 8'h00; e_rdy = 1'b0; e_ovr = 1'b0; e_fe = 1'b0;
        end else begin
            p = int'(bit_clocks); h = p / 2;
            line = m_s2; m_s2 = m_s1; m_s1 = ser_in;
            done = 1'b0; stop_v = 1'b1; tx_was = e_full;
            if (r_mode == 1) begin
                r_wait--;
                if (r_wait == 0) begin
                    if (!line) begin r_mode = 2; r_idx = 1; r_wait = p; end
                    else r_mode = 0;
                end
            end else if (r_mode == 2) begin
                r_wait--;
                if (r_wait == 0) begin
                    if (r_idx <= 8) r_sh[msb_first ? 8 - r_idx : r_idx - 1] = line;
                    if (r_idx == 10) begin done = 1'b1; stop_v = line; r_mode = 0; end
                    else begin r_idx++; r_wait = p; end
                end
            end else if (!tx_was) begin
                if (!line) begin
                    r_mode = 1; r_wait = h;
                end else if (tx_start) begin
                    nbits = two_stop ? 12 : 11;
                    for (int k = 0; k < nbits; k++)
                        for (int c = 0; c < p; c++)
                            mq.push_back(fbit(tx_byte, k, msb_first, parity_odd));
                end
            end
            if (done) begin
                e_ovr = e_ovr | e_rdy; e_rdy = 1'b1; e_fe = e_fe | !stop_v; e_byte = r_sh;
            end else if (flag_ack) begin
                e_rdy = 1'b0; e_ovr = 1'b0; e_fe = 1'b0;
            end
            if (mq.size() > 0) begin e_out = mq.pop_front(); e_full = 1'b1; end
            else begin e_out = 1'b1; e_full = 1'b0; end
        end
        if (cycles >= 150000) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
            finish_run();
        end
    end

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check(ser_out == e_out, "R2", "ser_out", ser_out, e_out);
            check(tx_full == e_full, "R5", "tx_full", tx_full, e_full);
            check(rx_active == (r_mode != 0), "R6", "rx_active", rx_active, r_mode != 0);
            check(rx_start_seen == (r_mode == 1), "R6", "rx_start_seen", rx_start_seen, r_mode == 1);
            check(rx_ready == e_rdy, "R7", "rx_ready", rx_ready, e_rdy);
            check(rx_byte == e_byte, "R7", "rx_byte", rx_byte, e_byte);
            check(rx_overrun == e_ovr, "R9", "rx_overrun", rx_overrun, e_ovr);
            check(rx_frame_err == e_fe, "R8", "rx_frame_err", rx_frame_err, e_fe);
        end
    end

    bit mon_en = 1'b0;
    int rdy_cycles = 0;
    always @(negedge clk) if (mon_en && rx_ready) rdy_cycles++;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Send one character and decode ser_out at mid-bit.
    task automatic send_tx(input logic [7:0] d);
        int p, h, n;
        string tag;
        p = int'(bit_clocks); h = p / 2; n = two_stop ? 12 : 11;
        tx_byte = d; tx_start = 1'b1;
        tick(1);
        tx_start = 1'b0;
        for (int k = 0; k < n; k++) begin
            tick(h);
            tag = (k == 0) ? "R2" : (k <= 8) ? "R3" : (k == 9) ? "R4" : "R5";
            check(ser_out == fbit(d, k, msb_first, parity_odd), tag, "tx frame bit",
                  ser_out, fbit(d, k, msb_first, parity_odd));
            if (k == n - 1) check(tx_full == 1'b1, "R5", "tx_full in last stop", tx_full, 1);
            tick(p - h);
        end
        check(tx_full == 1'b0, "R5", "tx_full after frame", tx_full, 0);
        check(ser_out == 1'b1, "R1", "ser_out idle after frame", ser_out, 1);
    endtask

    // Drive one received frame; collide raises tx_start on the detection cycle.
    task automatic drive_rx(input logic [7:0] d, input bit stop_v, input bit collide);
        int p, h;
        p = int'(bit_clocks); h = p / 2;
        for (int k = 0; k < 11; k++) begin
            ser_in = (k == 10) ? stop_v : fbit(d, k, msb_first, parity_odd);
            if (collide && k == 0) begin
                tick(2); tx_start = 1'b1; tick(p - 2);
            end else if (k == 5) begin
                tick(h);
                check(rx_active == 1'b1, "R11", "rx_active mid frame", rx_active, 1);
                check(tx_full == 1'b0, "R11", "tx_full during rx", tx_full, 0);
                check(ser_out == 1'b1, "R1", "ser_out during rx", ser_out, 1);
                tick(p - h);
            end else begin
                tick(p);
            end
        end
        ser_in = 1'b1;
        if (collide) tx_start = 1'b0;
        tick(2);
    endtask

    task automatic measure_com(input int cfg_v, input int exp_per);
        int per, hi;
        logic prev;
        clk_div_cfg = DIV_W'(cfg_v);
        tick(3 * exp_per + 2);
        do begin prev = com_clk; tick(1); end while (!(prev == 1'b0 && com_clk == 1'b1));
        per = 0; hi = 0;
        do begin
            if (com_clk) hi++;
            per++;
            prev = com_clk;
            tick(1);
        end while (!(prev == 1'b0 && com_clk == 1'b1));
        check(per == exp_per, "R12", "com_clk period", per, exp_per);
        check(hi == exp_per / 2, "R12", "com_clk high time", hi, exp_per / 2);
    endtask

    initial begin
        tick(4);
        check(ser_out == 1'b1, "R1", "reset ser_out", ser_out, 1);
        check(tx_full == 1'b0, "R1", "reset tx_full", tx_full, 0);
        check({rx_ready, rx_overrun, rx_frame_err} == 3'b000, "R1", "reset flags",
              {rx_ready, rx_overrun, rx_frame_err}, 0);
        check({rx_active, rx_start_seen} == 2'b00, "R1", "reset rx status",
              {rx_active, rx_start_seen}, 0);
        rst = 1'b0;
        tick(4);

        // transmit variants: R2 R3 R4 R5
        msb_first = 0; parity_odd = 0; two_stop = 0; send_tx(8'hA5); tick(3);
        msb_first = 1; parity_odd = 1; two_stop = 1; send_tx(8'h3C); tick(3);
        bit_clocks = 13'd12;
        msb_first = 0; parity_odd = 1; two_stop = 1; send_tx(8'h01); tick(3);
        msb_first = 1; parity_odd = 0; two_stop = 0; send_tx(8'hE8); tick(3);
        bit_clocks = 13'd16;

        // receive, both orders: R7 R3
        msb_first = 0; parity_odd = 0;
        drive_rx(8'h5A, 1'b1, 1'b0);
        check(rx_byte == 8'h5A && rx_ready, "R7", "rx lsb-first byte", rx_byte, 8'h5A);
        flag_ack = 1'b1; tick(1); flag_ack = 1'b0; tick(1);
        check(rx_ready == 1'b0, "R10", "ack clears ready", rx_ready, 0);
        msb_first = 1;
        drive_rx(8'hC1, 1'b1, 1'b0);
        check(rx_byte == 8'hC1, "R3", "rx msb-first byte", rx_byte, 8'hC1);
        check(rx_ready == 1'b1, "R10", "ready held without ack", rx_ready, 1);

        // overrun: R9
        drive_rx(8'h0F, 1'b1, 1'b0);
        check(rx_overrun == 1'b1, "R9", "overrun set", rx_overrun, 1);
        check(rx_byte == 8'h0F, "R9", "newer byte kept", rx_byte, 8'h0F);
        flag_ack = 1'b1; tick(1); flag_ack = 1'b0; tick(1);
        check(rx_overrun == 1'b0, "R10", "ack clears overrun", rx_overrun, 0);

        // framing error: R8
        msb_first = 0;
        drive_rx(8'h66, 1'b0, 1'b0);
        check(rx_frame_err == 1'b1, "R8", "stop low flagged", rx_frame_err, 1);
        tick(20);
        check(rx_frame_err == 1'b1, "R10", "frame_err sticky", rx_frame_err, 1);
        flag_ack = 1'b1; tick(1); flag_ack = 1'b0; tick(1);
        check(rx_frame_err == 1'b0, "R10", "ack clears frame_err", rx_frame_err, 0);

        // short glitch rejected: R6
        ser_in = 1'b0; tick(3); ser_in = 1'b1;
        check(rx_start_seen == 1'b1, "R6", "start qualification entered", rx_start_seen, 1);
        tick(16);
        check(rx_active == 1'b0, "R6", "glitch dropped", rx_active, 0);
        check(rx_ready == 1'b0, "R6", "glitch gives no char", rx_ready, 0);

        // completion in the same cycle as ack: R10
        flag_ack = 1'b1; mon_en = 1'b1; rdy_cycles = 0;
        drive_rx(8'h77, 1'b1, 1'b0);
        tick(2);
        mon_en = 1'b0; flag_ack = 1'b0;
        check(rdy_cycles == 1, "R10", "ready pulse under held ack", rdy_cycles, 1);
        check(rx_byte == 8'h77, "R10", "byte kept after ack", rx_byte, 8'h77);

        // start detection collides with a request: R11
        tx_byte = 8'h99;
        drive_rx(8'h2D, 1'b1, 1'b1);
        check(rx_byte == 8'h2D, "R11", "rx won collision", rx_byte, 8'h2D);
        tick(12 * 16 + 8);
        flag_ack = 1'b1; tick(1); flag_ack = 1'b0; tick(2);

        // communication clock: R12
        measure_com(4, 4);
        measure_com(7, 7);
        measure_com(1, 2);

        // default smart-card bit period: R13
        bit_clocks = 13'd372; msb_first = 0; parity_odd = 1; two_stop = 1;
        send_tx(8'h96);
        check(tx_full == 1'b0, "R13", "372-clock frame ended", tx_full, 0);
        tick(3);
        drive_rx(8'hB4, 1'b1, 1'b0);
        check(rx_byte == 8'hB4 && rx_ready, "R13", "372-clock rx byte", rx_byte, 8'hB4);

        tick(5);
        finish_run();
    end
endmodule